// File: doc/BRIEF.md
# Programmable Interrupt Countdown Timer

This block counts a programmed value down to zero and, each time it expires, raises a one-cycle interrupt-request strobe that carries an 8-bit vector. The count is clocked from the bus clock through a prescaler. The prescaler divides by a power of two between 1 and 128, and a sparse code in the divide register picks the divisor. On each prescaler boundary the count drops by a fixed step, `STEP`. The default step is 1.

Two behaviours are set by a timer entry register: one-shot and periodic. In one-shot mode the count stops at zero after the single expiry. In periodic mode the count reloads from the initial value, and any overshoot past zero is carried over into the reload. A mask bit in the entry blocks the strobe but does not stop the counting. A software-enable bit lives in a separate control register. While that bit is clear, every write to the entry comes out masked.

Software drives one write port with a 2-bit register select. The current count is always visible on an output.

Top module: `irq_countdown_timer`

## Requirements
- R1: After reset the current count is 0, no strobe is issued, the entry mask reads as set, the software-enable bit is clear and the divide code is 0 (divide by 2).
- R2: Only bits 3, 1 and 0 of the divide register (select 1, data bits [3:0]) choose the divisor: 0x0→2, 0x1→4, 0x2→8, 0x3→16, 0x8→32, 0x9→64, 0xA→128, 0xB→1. Bit 2 and all higher bits are ignored.
- R3: A write to select 0 loads both the initial count and the current count with data[WIDTH-1:0] and restarts the prescaler. After that, the count drops by STEP at the end of every divisor cycles.
- R4: While the initial count is 0, no expiry occurs and the current count stays 0.
- R5: In one-shot mode (entry bit 17 = 0), a decrement that would reach or pass zero sets the count to 0 and fires once. From then on the count stays 0 and nothing fires until select 0 is written again.
- R6: In periodic mode (entry bit 17 = 1), a decrement that would reach or pass zero fires and reloads the count with initial − (STEP − count). If that overshoot is not less than the initial count, the count becomes 0 instead.
- R7: An expiry raises irq_valid with irq_vector = entry bits [7:0] only while the mask (entry bit 16) is clear. Counting and reloading go on whether or not the mask is set.
- R8: A write to the entry (select 2) while the software-enable bit (select 3, data bit 8) is clear stores the mask as set, whatever data bit 16 holds.
- R9: A new divide code takes effect only at the next prescaler boundary, or at a select-0 write. The period that is already running finishes with the old divisor.
- R10: irq_valid is high for exactly the clock following the edge at which the expiring count update is stored, so the strobe and the new count appear together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 initial count, 1 divide, 2 timer entry, 3 control |
| wr_data | input | 32 | Write data |
| cur_count | output | WIDTH | Current count |
| irq_valid | output | 1 | Interrupt-request strobe |
| irq_vector | output | 8 | Vector carried by the strobe |

## Verification
A wrong prescaler phase or a wrong divisor shows up on cur_count within one divisor period, because the count steps early or late. A wrong reload shows up at the first expiry in periodic mode, because the count lands on a value other than initial minus overshoot. A stale mask or mode bit shows up at the first expiry, either as a strobe that should not be there or as a count that stops or keeps running against the mode. The bench compares cur_count, irq_valid and irq_vector against an arithmetic model on every clock. It covers all sixteen divide codes, both modes and initial counts below, at and above the step, so any of these faults is caught within a few prescaler periods.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    SEL_INIT  = 2'd0,
    SEL_DIV   = 2'd1,
    SEL_ENTRY = 2'd2,
    SEL_CTRL  = 2'd3
  } tmr_sel_e;

  localparam int VEC_W       = 8;
  localparam int SHIFT_W     = 3;
  localparam int ENTRY_MASK  = 16;
  localparam int ENTRY_PER   = 17;
  localparam int CTRL_ENABLE = 8;

  // Sparse code {b3,b1,b0} -> log2(divisor); index n selects 2^((n+1) mod 8)
  function automatic logic [SHIFT_W-1:0] shift_of(input logic [3:0] code);
    logic [SHIFT_W-1:0] idx;
    idx = {code[3], code[1], code[0]};
    return idx + SHIFT_W'(1);
  endfunction
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [1:0]         wr_sel,
  input  logic [31:0]        wr_data,
  output logic [3:0]         div_code,
  output logic [VEC_W-1:0]   vector,
  output logic               mask,
  output logic               periodic,
  output logic               sw_en
);
  always_ff @(posedge clk) begin
    if (rst) begin
      div_code <= 4'd0;
      vector   <= '0;
      mask     <= 1'b1;
      periodic <= 1'b0;
      sw_en    <= 1'b0;
    end else if (wr_en) begin
      case (tmr_sel_e'(wr_sel))
        SEL_DIV:   div_code <= wr_data[3:0];
        SEL_ENTRY: begin
          vector   <= wr_data[VEC_W-1:0];
          periodic <= wr_data[ENTRY_PER];
          mask     <= wr_data[ENTRY_MASK] | ~sw_en;
        end
        SEL_CTRL:  sw_en <= wr_data[CTRL_ENABLE];
        default:   ;
      endcase
    end
  end

  AST_FORCE_MASK: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == SEL_ENTRY && !sw_en) |=> mask); // R8
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import tmr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       restart,
  input  logic [3:0] div_code,
  output logic       tick
);
  localparam int CNT_W = (1 << SHIFT_W) - 1;

  logic [SHIFT_W-1:0] shift_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [CNT_W-1:0]   limit;

  assign limit = CNT_W'((1 << shift_q) - 1);
  assign tick  = (cnt_q == limit);

  always_ff @(posedge clk) begin
    if (rst) begin
      shift_q <= shift_of(4'd0);
      cnt_q   <= '0;
    end else if (restart || tick) begin
      shift_q <= shift_of(div_code);
      cnt_q   <= '0;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  AST_PRESCALE_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (!tick && !restart) |=> (cnt_q == $past(cnt_q) + CNT_W'(1))); // R9
  AST_PRESCALE_SHIFT_HELD: assert property (@(posedge clk) disable iff (rst)
    (!tick && !restart) |=> $stable(shift_q)); // R9
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
  import tmr_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int STEP  = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [WIDTH-1:0] load_val,
  input  logic             tick,
  input  logic             periodic,
  input  logic             mask,
  input  logic [VEC_W-1:0] vector,
  output logic [WIDTH-1:0] count,
  output logic             irq_valid,
  output logic [VEC_W-1:0] irq_vector
);
  localparam logic [WIDTH-1:0] STEP_V = WIDTH'(STEP);

  logic [WIDTH-1:0] init_q;
  logic [WIDTH-1:0] cur_q;
  logic [WIDTH-1:0] cur_d;
  logic [WIDTH-1:0] over;
  logic             fire;

  always_comb begin
    cur_d = cur_q;
    fire  = 1'b0;
    over  = STEP_V - cur_q;
    if (load) begin
      cur_d = load_val;
    end else if (tick && init_q != '0) begin
      if (cur_q > STEP_V) begin
        cur_d = cur_q - STEP_V;
      end else if (periodic) begin
        fire  = 1'b1;
        cur_d = (over < init_q) ? (init_q - over) : '0;
      end else if (cur_q != '0) begin
        fire  = 1'b1;
        cur_d = '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      init_q     <= '0;
      cur_q      <= '0;
      irq_valid  <= 1'b0;
      irq_vector <= '0;
    end else begin
      if (load) init_q <= load_val;
      cur_q     <= cur_d;
      irq_valid <= fire & ~mask;
      if (fire) irq_vector <= vector;
    end
  end

  assign count = cur_q;

  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (rst)
    (tick && !load && cur_q > STEP_V && init_q != '0) |=> (cur_q == $past(cur_q) - STEP_V)); // R3
  AST_IDLE_WHEN_ZERO: assert property (@(posedge clk) disable iff (rst)
    (init_q == '0 && !load) |=> (!irq_valid && cur_q == $past(cur_q))); // R4
  AST_ONESHOT_STAYS: assert property (@(posedge clk) disable iff (rst)
    (!periodic && cur_q == '0 && !load) |=> (cur_q == '0 && !irq_valid)); // R5
  AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (rst)
    (!tick && !load) |=> ($stable(cur_q) && !irq_valid)); // R10
endmodule

// File: rtl/irq_countdown_timer.sv
module irq_countdown_timer
  import tmr_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int STEP  = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [31:0]      wr_data,
  output logic [WIDTH-1:0] cur_count,
  output logic             irq_valid,
  output logic [VEC_W-1:0] irq_vector
);
  logic [3:0]       div_code;
  logic [VEC_W-1:0] vector;
  logic             mask;
  logic             periodic;
  logic             sw_en;
  logic             tick;
  logic             load;

  assign load = wr_en && (wr_sel == SEL_INIT);

  tmr_regs u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .div_code(div_code), .vector(vector), .mask(mask),
    .periodic(periodic), .sw_en(sw_en)
  );

  tmr_prescaler u_pre (
    .clk(clk), .rst(rst), .restart(load), .div_code(div_code), .tick(tick)
  );

  tmr_counter #(.WIDTH(WIDTH), .STEP(STEP)) u_cnt (
    .clk(clk), .rst(rst), .load(load), .load_val(wr_data[WIDTH-1:0]),
    .tick(tick), .periodic(periodic), .mask(mask), .vector(vector),
    .count(cur_count), .irq_valid(irq_valid), .irq_vector(irq_vector)
  );

  AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (rst)
    irq_valid |-> !$past(mask)); // R7
  AST_VECTOR_MATCH: assert property (@(posedge clk) disable iff (rst)
    irq_valid |-> (irq_vector == $past(vector))); // R7
endmodule

// File: tb/sim_irq_countdown_timer.sv
module sim_irq_countdown_timer;
  localparam int CLK_PERIOD = 10;
  localparam int W    = 16;
  localparam int STEP = 3;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         wr_en = 1'b0;
  logic [1:0]   wr_sel = 2'd0;
  logic [31:0]  wr_data = 32'd0;
  logic [W-1:0] cur_count;
  logic         irq_valid;
  logic [7:0]   irq_vector;

  int n_chk = 0;
  int n_bad = 0;
  string tag = "R1";

  // bench model state
  int m_cnt, m_div, m_cur, m_init, m_code, m_vec, m_mask, m_per, m_en;
  int e_irq, e_vec;
  int n_irq_seen;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_countdown_timer #(.WIDTH(W), .STEP(STEP)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .cur_count(cur_count), .irq_valid(irq_valid), .irq_vector(irq_vector)
  );

  // R2 divisor table
  function automatic int div_of(input int code);
    case (code & 'hB)
      'h0: return 2;   'h1: return 4;   'h2: return 8;   'h3: return 16;
      'h8: return 32;  'h9: return 64;  'hA: return 128; default: return 1;
    endcase
  endfunction

  task automatic check(input string t, input int act, input int exp, input string what);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", t, what, act, exp);
    end
  endtask

  task automatic compare();
    check(tag, int'(cur_count), m_cur, "count");
    check(tag, int'(irq_valid), e_irq, "irq_valid");
    if (e_irq != 0) check(tag, int'(irq_vector), e_vec, "irq_vector");
    if (irq_valid) n_irq_seen++;
  endtask

  task automatic step(input bit we, input int sel, input int d);
    int n_cnt, n_div, n_cur, n_init, n_code, n_vec, n_mask, n_per, n_en, fire, over;
    bit tk, ld;
    wr_en = we; wr_sel = sel[1:0]; wr_data = d;
    tk = (m_cnt == m_div - 1);
    ld = we && sel == 0;
    n_cnt = m_cnt + 1; n_div = m_div;
    if (ld || tk) begin n_cnt = 0; n_div = div_of(m_code); end
    n_cur = m_cur; n_init = m_init; fire = 0;
    if (ld) begin n_cur = d & 'hFFFF; n_init = d & 'hFFFF; end
    else if (tk && m_init != 0) begin
      if (m_cur > STEP) n_cur = m_cur - STEP;
      else if (m_per != 0) begin
        fire = 1; over = STEP - m_cur;
        n_cur = (over < m_init) ? m_init - over : 0;
      end else if (m_cur != 0) begin fire = 1; n_cur = 0; end
    end
    n_code = m_code; n_vec = m_vec; n_mask = m_mask; n_per = m_per; n_en = m_en;
    if (we && sel == 1) n_code = d & 'hF;
    if (we && sel == 2) begin
      n_vec = d & 'hFF; n_per = (d >> 17) & 1;
      n_mask = (((d >> 16) & 1) != 0 || m_en == 0) ? 1 : 0;
    end
    if (we && sel == 3) n_en = (d >> 8) & 1;
    e_irq = (fire != 0 && m_mask == 0) ? 1 : 0;
    if (fire != 0) e_vec = m_vec;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    m_cnt = n_cnt; m_div = n_div; m_cur = n_cur; m_init = n_init;
    m_code = n_code; m_vec = n_vec; m_mask = n_mask; m_per = n_per; m_en = n_en;
    compare();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 0, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    m_cnt = 0; m_div = 2; m_cur = 0; m_init = 0; m_code = 0; m_vec = 0;
    m_mask = 1; m_per = 0; m_en = 0; e_irq = 0; e_vec = 0; n_irq_seen = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    tag = "R1"; compare();
    idle(6);

    // R8: entry written with enable clear stays masked; count runs, no strobe
    tag = "R8";
    step(1'b1, 2, 32'h0002_0055);
    step(1'b1, 1, 32'hB);
    step(1'b1, 0, 5);
    n_irq_seen = 0;
    idle(30);
    check("R8", n_irq_seen, 0, "strobes while masked");

    // R4: zero initial count disables expiry
    tag = "R4";
    step(1'b1, 3, 32'h100);
    step(1'b1, 2, 32'h0002_0011);
    step(1'b1, 0, 0);
    idle(40);

    // R2/R3/R5/R6: sweep all divide codes, both modes, several initial counts
    for (int code = 0; code < 16; code++) begin
      for (int per = 0; per < 2; per++) begin
        for (int k = 0; k < 5; k++) begin
          int iv;
          iv = (k == 0) ? 1 : (k == 1) ? 2 : (k == 2) ? 3 : (k == 3) ? 5 : 7;
          tag = (per != 0) ? "R6" : "R5";
          step(1'b1, 1, code | 32'hFFF0_0004);  // high bits and bit 2 ignored (R2)
          step(1'b1, 2, (per << 17) | ((code * 16 + iv) & 'hFF));
          tag = "R3";
          step(1'b1, 0, iv);
          tag = (per != 0) ? "R6" : "R5";
          idle(div_of(code) * 8);
        end
      end
    end

    // R7: mask set, periodic keeps counting without strobes
    tag = "R7";
    step(1'b1, 1, 32'h0);
    step(1'b1, 2, 32'h0003_00AA);
    step(1'b1, 0, 4);
    n_irq_seen = 0;
    idle(40);
    check("R7", n_irq_seen, 0, "strobes with mask set");
    step(1'b1, 2, 32'h0002_00AB);
    idle(40);

    // R9: divide change mid-period applies at the next boundary
    tag = "R9";
    step(1'b1, 1, 32'hA);
    step(1'b1, 0, 9);
    idle(50);
    step(1'b1, 1, 32'hB);
    idle(300);

    // R10: fast periodic expiry back-to-back strobes
    tag = "R10";
    step(1'b1, 0, 2);
    n_irq_seen = 0;
    idle(20);
    check("R10", (n_irq_seen > 10) ? 1 : 0, 1, "strobe cadence");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule